// File: doc/BRIEF.md
# Compatibility register file with legacy status view

This block holds the working registers of a 16-bit CPU: eight word registers, each also reachable as a low byte and a high byte. The first four words are banked, with four copies selected by a two-bit bank field in the status state. The last four words are global and ignore the bank field. Reads are combinational. Writes take effect at the clock edge and cover either a full word or one byte.

A second layer serves code translated from an older 8-bit accumulator machine. It exposes aliased bytes: the accumulator is the low byte of word 4 and its partner byte is the high byte of word 4. A 16-bit data pointer lives in word 6. The layer also provides a legacy status byte at its own special-register address, next to the native status byte. That legacy byte carries a live parity bit for the accumulator and two flags that exist only in this view.

When the compatibility input is high, the indirect-address output is built from one of the first two bytes of the register file, zero-extended to 16 bits. When the input is low, it is the full word register that is named. The register and status ports have no handshake: every access completes in one cycle.

Top module: `cfv_regfile`

## Requirements
- R1: A word write (`wr_byte`=0) replaces the whole register. A byte write (`wr_byte`=1) stores `wr_data[7:0]` into the high half when `wr_hi`=1 and into the low half otherwise, leaving the other half unchanged. A word read returns the register. A byte read returns the selected half zero-extended to 16 bits.
- R2: `acc_o` equals bits 7:0 of register 4, `b_o` equals bits 15:8 of register 4, and `dptr_o` equals register 6 (low byte DPL, high byte DPH).
- R3: Register indices 0 to 3 access the copy in the bank given by the current bank field. Indices 4 to 7 reach the same storage in every bank.
- R4: At special address `LEG_ADDR` (default 0x41) the read value is, from bit 7 down to bit 0: carry, aux-carry, flag0, bank[1], bank[0], overflow, flag1, parity.
- R5: The parity bit equals the XOR of the eight accumulator bits, so it is 1 when the accumulator holds an odd number of ones. It follows every change of the accumulator in the same cycle, with no write needed.
- R6: Flag0 and flag1 are stored by a write to `LEG_ADDR` and read back unchanged. They do not appear in the native status byte.
- R7: A write to `LEG_ADDR` updates carry, aux-carry, overflow and the bank field in the shared status state. Bit 0 of the written data is ignored.
- R8: At special address `NAT_ADDR` (default 0x40) the native status byte reads carry in bit 7, aux-carry in bit 6, overflow in bit 5 and the bank field in bits 1:0, with bits 4:2 reading 0. A write to it updates those fields and leaves flag0 and flag1 untouched.
- R9: With `compat_en`=1, `ind_addr` is the low byte of register 0 in the current bank when `ind_reg[0]`=0, or its high byte when `ind_reg[0]`=1, in either case with the upper 8 bits zero.
- R10: With `compat_en`=0, `ind_addr` equals the word register selected by `ind_reg`, with banking applied.
- R11: `compat_en` has no effect on register reads, register writes or status accesses.
- R12: Special-register reads at other addresses return 0, and writes to them change nothing.
- R13: After reset every register, flag and status field is 0, so both status bytes read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| compat_en | input | 1 | Compatibility mode for indirect addressing |
| rd_idx | input | 3 | Read register index |
| rd_byte | input | 1 | Read one byte instead of the word |
| rd_hi | input | 1 | Byte read selects the high half |
| rd_data | output | 16 | Read data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 3 | Write register index |
| wr_byte | input | 1 | Byte write |
| wr_hi | input | 1 | Byte write targets the high half |
| wr_data | input | 16 | Write data |
| sfr_we | input | 1 | Special-register write enable |
| sfr_addr | input | 8 | Special-register address |
| sfr_wdata | input | 8 | Special-register write data |
| sfr_rdata | output | 8 | Special-register read data |
| ind_reg | input | 3 | Indirect pointer select |
| ind_addr | output | 16 | Indirect address |
| acc_o | output | 8 | Accumulator alias byte |
| b_o | output | 8 | Partner byte alias |
| dptr_o | output | 16 | Data-pointer alias |

## Verification
On every cycle, the assertions check the following:
- the parity bit against the accumulator alias;
- the zero upper byte of compat-mode indirect addresses;
- that a non-compat indirect address matches a word read of the same register;
- that a legacy-status write lands in the shared state;
- that status holds when nothing writes it;
- that the global aliases hold when no register is written.

Only the bench's scenarios can show the following:
- that bank switching isolates registers 0 to 3 and leaves 4 to 7 shared;
- that byte writes preserve the other half;
- that native-status writes leave the two legacy flags alone;
- that unknown addresses and P writes have no effect.

// File: rtl/cfv_pkg.sv
package cfv_pkg;
  localparam int CFV_DW      = 16;
  localparam int CFV_NBANKS  = 4;
  localparam int CFV_NBANKED = 4;
  localparam int CFV_NGLOBAL = 4;
  localparam int CFV_AW      = 8;

  typedef struct packed {
    logic       c;
    logic       ac;
    logic       ov;
    logic [1:0] bank;
  } cfv_stat_t;
endpackage

// File: rtl/cfv_store.sv
module cfv_store
  import cfv_pkg::*;
#(
  parameter int DW      = CFV_DW,
  parameter int NBANKS  = CFV_NBANKS,
  parameter int NBANKED = CFV_NBANKED,
  parameter int NGLOBAL = CFV_NGLOBAL,
  localparam int NREGS  = NBANKED + NGLOBAL,
  localparam int IW     = $clog2(NREGS),
  localparam int BKW    = $clog2(NBANKS),
  localparam int HW     = DW / 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [BKW-1:0]            bank_sel,
  input  logic                      wr_en,
  input  logic [IW-1:0]             wr_idx,
  input  logic                      wr_byte,
  input  logic                      wr_hi,
  input  logic [DW-1:0]             wr_data,
  output logic [NREGS-1:0][DW-1:0]  view
);
  localparam int NBK_WORDS = NBANKS * NBANKED;

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old);
    logic [DW-1:0] m;
    if (!wr_byte)   m = wr_data;
    else if (wr_hi) m = {wr_data[HW-1:0], old[HW-1:0]};
    else            m = {old[DW-1:HW], wr_data[HW-1:0]};
    return m;
  endfunction

  logic [DW-1:0] bk_flat [NBK_WORDS];
  logic [DW-1:0] gl_flat [NGLOBAL];

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    for (genvar r = 0; r < NBANKED; r++) begin : g_reg
      logic [DW-1:0] q;
      logic          hit;
      assign hit = wr_en && (bank_sel == BKW'(b)) && (wr_idx == IW'(r));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (hit) q <= merge(q);
      end
      assign bk_flat[b*NBANKED + r] = q;
    end
  end

  for (genvar g = 0; g < NGLOBAL; g++) begin : g_glob
    logic [DW-1:0] q;
    logic          hit;
    assign hit = wr_en && (wr_idx == IW'(NBANKED + g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (hit) q <= merge(q);
    end
    assign gl_flat[g] = q;
  end

  always_comb begin
    for (int r = 0; r < NBANKED; r++)
      view[r] = bk_flat[int'(bank_sel)*NBANKED + r];
    for (int g = 0; g < NGLOBAL; g++)
      view[NBANKED + g] = gl_flat[g];
  end
endmodule

// File: rtl/cfv_status.sv
module cfv_status
  import cfv_pkg::*;
#(
  parameter int                AW       = CFV_AW,
  parameter logic [AW-1:0]     NAT_ADDR = 8'h40,
  parameter logic [AW-1:0]     LEG_ADDR = 8'h41
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sfr_we,
  input  logic [AW-1:0] sfr_addr,
  input  logic [7:0]    sfr_wdata,
  input  logic [7:0]    acc,
  output logic [7:0]    sfr_rdata,
  output cfv_stat_t     st,
  output logic          f0,
  output logic          f1
);
  logic      par;
  logic [7:0] leg_byte, nat_byte;
  cfv_stat_t  st_q;
  logic       f0_q, f1_q;

  assign par = ^acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      f0_q <= 1'b0;
      f1_q <= 1'b0;
    end else if (sfr_we && sfr_addr == LEG_ADDR) begin
      st_q.c    <= sfr_wdata[7];
      st_q.ac   <= sfr_wdata[6];
      f0_q      <= sfr_wdata[5];
      st_q.bank <= sfr_wdata[4:3];
      st_q.ov   <= sfr_wdata[2];
      f1_q      <= sfr_wdata[1];
    end else if (sfr_we && sfr_addr == NAT_ADDR) begin
      st_q.c    <= sfr_wdata[7];
      st_q.ac   <= sfr_wdata[6];
      st_q.ov   <= sfr_wdata[5];
      st_q.bank <= sfr_wdata[1:0];
    end
  end

  assign leg_byte = {st_q.c, st_q.ac, f0_q, st_q.bank, st_q.ov, f1_q, par};
  assign nat_byte = {st_q.c, st_q.ac, st_q.ov, 3'b000, st_q.bank};

  always_comb begin
    if (sfr_addr == LEG_ADDR)      sfr_rdata = leg_byte;
    else if (sfr_addr == NAT_ADDR) sfr_rdata = nat_byte;
    else                           sfr_rdata = '0;
  end

  assign st = st_q;
  assign f0 = f0_q;
  assign f1 = f1_q;
endmodule

// File: rtl/cfv_indirect.sv
module cfv_indirect
  import cfv_pkg::*;
#(
  parameter int  DW    = CFV_DW,
  parameter int  NREGS = CFV_NBANKED + CFV_NGLOBAL,
  localparam int IW    = $clog2(NREGS),
  localparam int HW    = DW / 2
) (
  input  logic                     compat_en,
  input  logic [IW-1:0]            ind_reg,
  input  logic [NREGS-1:0][DW-1:0] view,
  output logic [DW-1:0]            ind_addr
);
  logic [HW-1:0] ptr_byte;

  assign ptr_byte = ind_reg[0] ? view[0][DW-1:HW] : view[0][HW-1:0];

  always_comb begin
    if (compat_en) ind_addr = {{(DW-HW){1'b0}}, ptr_byte};
    else           ind_addr = view[ind_reg];
  end
endmodule

// File: rtl/cfv_regfile.sv
module cfv_regfile
  import cfv_pkg::*;
#(
  parameter int            DW       = CFV_DW,
  parameter int            AW       = CFV_AW,
  parameter logic [AW-1:0] NAT_ADDR = 8'h40,
  parameter logic [AW-1:0] LEG_ADDR = 8'h41
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          compat_en,
  input  logic [2:0]    rd_idx,
  input  logic          rd_byte,
  input  logic          rd_hi,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [2:0]    wr_idx,
  input  logic          wr_byte,
  input  logic          wr_hi,
  input  logic [DW-1:0] wr_data,
  input  logic          sfr_we,
  input  logic [AW-1:0] sfr_addr,
  input  logic [7:0]    sfr_wdata,
  output logic [7:0]    sfr_rdata,
  input  logic [2:0]    ind_reg,
  output logic [DW-1:0] ind_addr,
  output logic [7:0]    acc_o,
  output logic [7:0]    b_o,
  output logic [DW-1:0] dptr_o
);
  localparam int NREGS   = CFV_NBANKED + CFV_NGLOBAL;
  localparam int HW      = DW / 2;
  localparam int ACC_REG = CFV_NBANKED;
  localparam int DP_REG  = CFV_NBANKED + 2;

  logic [NREGS-1:0][DW-1:0] view;
  cfv_stat_t                st;
  logic                     f0, f1;

  cfv_store #(.DW(DW), .NBANKS(CFV_NBANKS), .NBANKED(CFV_NBANKED),
              .NGLOBAL(CFV_NGLOBAL)) u_store (
    .clk(clk), .rst_n(rst_n), .bank_sel(st.bank),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_byte(wr_byte), .wr_hi(wr_hi),
    .wr_data(wr_data), .view(view)
  );

  cfv_status #(.AW(AW), .NAT_ADDR(NAT_ADDR), .LEG_ADDR(LEG_ADDR)) u_status (
    .clk(clk), .rst_n(rst_n), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .acc(acc_o), .sfr_rdata(sfr_rdata),
    .st(st), .f0(f0), .f1(f1)
  );

  cfv_indirect #(.DW(DW), .NREGS(NREGS)) u_ind (
    .compat_en(compat_en), .ind_reg(ind_reg), .view(view), .ind_addr(ind_addr)
  );

  always_comb begin
    if (!rd_byte)   rd_data = view[rd_idx];
    else if (rd_hi) rd_data = {{HW{1'b0}}, view[rd_idx][DW-1:HW]};
    else            rd_data = {{HW{1'b0}}, view[rd_idx][HW-1:0]};
  end

  assign acc_o  = view[ACC_REG][7:0];
  assign b_o    = view[ACC_REG][15:8];
  assign dptr_o = view[DP_REG];
endmodule

// File: rtl/cfv_regfile_chk.sv
module cfv_regfile_chk
  import cfv_pkg::*;
#(
  parameter int            DW       = CFV_DW,
  parameter int            AW       = CFV_AW,
  parameter logic [AW-1:0] LEG_ADDR = 8'h41
) (
  input logic          clk,
  input logic          rst_n,
  input logic          compat_en,
  input logic [2:0]    rd_idx,
  input logic          rd_byte,
  input logic [DW-1:0] rd_data,
  input logic          wr_en,
  input logic [2:0]    wr_idx,
  input logic          wr_byte,
  input logic [DW-1:0] wr_data,
  input logic          sfr_we,
  input logic [AW-1:0] sfr_addr,
  input logic [7:0]    sfr_wdata,
  input logic [7:0]    sfr_rdata,
  input logic [2:0]    ind_reg,
  input logic [DW-1:0] ind_addr,
  input logic [7:0]    acc_o,
  input logic [7:0]    b_o,
  input logic [DW-1:0] dptr_o,
  input cfv_stat_t     st,
  input logic          f0,
  input logic          f1
);
  // R5
  parity_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_addr == LEG_ADDR) |-> (sfr_rdata[0] == ^acc_o));

  // R9
  ind_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    compat_en |-> (ind_addr[DW-1:8] == '0));

  // R10
  ind_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!compat_en && !rd_byte && rd_idx == ind_reg) |-> (ind_addr == rd_data));

  // R2
  acc_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_byte && wr_idx == 3'd4) |=>
      (acc_o == $past(wr_data[7:0]) && b_o == $past(wr_data[15:8])));

  // R7
  leg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_we && sfr_addr == LEG_ADDR) |=>
      (st.c == $past(sfr_wdata[7]) && st.ac == $past(sfr_wdata[6]) &&
       st.bank == $past(sfr_wdata[4:3]) && st.ov == $past(sfr_wdata[2]) &&
       f0 == $past(sfr_wdata[5]) && f1 == $past(sfr_wdata[1])));

  // R12
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sfr_we |=> ($stable(st) && $stable(f0) && $stable(f1)));

  // R3
  global_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(acc_o) && $stable(b_o) && $stable(dptr_o)));
endmodule

bind cfv_regfile cfv_regfile_chk #(.DW(DW), .AW(AW), .LEG_ADDR(LEG_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .compat_en(compat_en), .rd_idx(rd_idx),
  .rd_byte(rd_byte), .rd_data(rd_data), .wr_en(wr_en), .wr_idx(wr_idx),
  .wr_byte(wr_byte), .wr_data(wr_data), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
  .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .ind_reg(ind_reg),
  .ind_addr(ind_addr), .acc_o(acc_o), .b_o(b_o), .dptr_o(dptr_o),
  .st(st), .f0(f0), .f1(f1)
);

// File: tb/cfv_regfile_test.sv
module cfv_regfile_test;
  localparam logic [7:0] NAT = 8'h40;
  localparam logic [7:0] LEG = 8'h41;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic compat_en = 1'b0;
  logic [2:0] rd_idx = '0, wr_idx = '0, ind_reg = '0;
  logic rd_byte = 1'b0, rd_hi = 1'b0, wr_en = 1'b0, wr_byte = 1'b0, wr_hi = 1'b0;
  logic [15:0] wr_data = '0;
  logic sfr_we = 1'b0;
  logic [7:0] sfr_addr = '0, sfr_wdata = '0;
  logic [15:0] rd_data, ind_addr, dptr_o;
  logic [7:0] sfr_rdata, acc_o, b_o;

  cfv_regfile uut (.*);

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [15:0] m_bk [4][4];
  logic [15:0] m_gl [4];
  logic m_c, m_ac, m_ov, m_f0, m_f1;
  logic [1:0] m_bank;

  function automatic logic [15:0] m_word(input int idx);
    return (idx < 4) ? m_bk[m_bank][idx] : m_gl[idx-4];
  endfunction
  function automatic logic [7:0] m_leg();
    logic [7:0] a = m_gl[0][7:0];
    return {m_c, m_ac, m_f0, m_bank, m_ov, m_f1, ^a};
  endfunction
  function automatic logic [7:0] m_nat();
    return {m_c, m_ac, m_ov, 3'b000, m_bank};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input int idx, input bit byt, input bit hi, input logic [15:0] d);
    logic [15:0] o;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'(idx); wr_byte = byt; wr_hi = hi; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    o = m_word(idx);
    if (!byt) o = d;
    else if (hi) o[15:8] = d[7:0];
    else o[7:0] = d[7:0];
    if (idx < 4) m_bk[m_bank][idx] = o; else m_gl[idx-4] = o;
  endtask

  task automatic sfr_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_we = 1'b1; sfr_addr = a; sfr_wdata = d;
    @(negedge clk);
    sfr_we = 1'b0;
    if (a == LEG) begin
      m_c = d[7]; m_ac = d[6]; m_f0 = d[5]; m_bank = d[4:3]; m_ov = d[2]; m_f1 = d[1];
    end else if (a == NAT) begin
      m_c = d[7]; m_ac = d[6]; m_ov = d[5]; m_bank = d[1:0];
    end
  endtask

  task automatic rd_chk(input string req, input int idx, input bit byt, input bit hi);
    logic [15:0] w;
    rd_idx = 3'(idx); rd_byte = byt; rd_hi = hi;
    #1;
    w = m_word(idx);
    check(req, rd_data, !byt ? w : (hi ? {8'h0, w[15:8]} : {8'h0, w[7:0]}));
  endtask

  task automatic sfr_chk(input string req, input logic [7:0] a);
    logic [7:0] e;
    sfr_addr = a;
    #1;
    e = (a == LEG) ? m_leg() : ((a == NAT) ? m_nat() : 8'h00);
    check(req, {8'h0, sfr_rdata}, {8'h0, e});
  endtask

  task automatic ind_chk(input string req, input bit cm, input int r);
    logic [15:0] e;
    compat_en = cm; ind_reg = 3'(r);
    #1;
    if (cm) e = (r % 2) ? {8'h0, m_bk[m_bank][0][15:8]} : {8'h0, m_bk[m_bank][0][7:0]};
    else e = m_word(r);
    check(req, ind_addr, e);
  endtask

  task automatic alias_chk();
    #1;
    check("R2 acc", {8'h0, acc_o}, {8'h0, m_gl[0][7:0]});
    check("R2 b", {8'h0, b_o}, {8'h0, m_gl[0][15:8]});
    check("R2 dptr", dptr_o, m_gl[2]);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=hang exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int b = 0; b < 4; b++) for (int r = 0; r < 4; r++) m_bk[b][r] = '0;
    for (int g = 0; g < 4; g++) m_gl[g] = '0;
    {m_c, m_ac, m_ov, m_f0, m_f1, m_bank} = '0;
    repeat (3) @(negedge clk);
    // R13 reset state
    for (int i = 0; i < 8; i++) rd_chk("R13 reset reg", i, 0, 0);
    sfr_chk("R13 reset legacy", LEG);
    sfr_chk("R13 reset native", NAT);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 byte writes keep other half
    reg_wr(5, 0, 0, 16'hA55A);
    reg_wr(5, 1, 1, 16'h00C3);
    rd_chk("R1 hi byte", 5, 0, 0);
    reg_wr(5, 1, 0, 16'hFF17);
    rd_chk("R1 lo byte", 5, 0, 0);
    rd_chk("R1 byte read hi", 5, 1, 1);
    rd_chk("R1 byte read lo", 5, 1, 0);

    // R2, R5: accumulator alias and parity
    reg_wr(4, 0, 0, 16'h3407);
    alias_chk();
    sfr_addr = LEG; #1;
    check("R5 parity odd", {15'h0, sfr_rdata[0]}, 16'd1);
    reg_wr(4, 1, 0, 16'h0003);
    sfr_addr = LEG; #1;
    check("R5 parity even", {15'h0, sfr_rdata[0]}, 16'd0);
    reg_wr(6, 0, 0, 16'hBEEF);
    alias_chk();

    // R7: write legacy view, P ignored
    sfr_wr(LEG, 8'hFF);
    sfr_chk("R7 legacy all ones", LEG);
    sfr_chk("R6 native hides flags", NAT);
    // R8: native write leaves flags
    sfr_wr(NAT, 8'h00);
    sfr_chk("R8 native clear", NAT);
    sfr_chk("R8 flags kept", LEG);
    // R12: other address
    sfr_wr(8'h7E, 8'hFF);
    sfr_chk("R12 other read", 8'h7E);
    sfr_chk("R12 legacy unchanged", LEG);

    // R3 banking
    for (int b = 0; b < 4; b++) begin
      sfr_wr(NAT, 8'(b));
      reg_wr(0, 0, 0, 16'(16'h1100 * (b + 1) + 16'h0022));
      reg_wr(7, 0, 0, 16'(16'h0700 + b));
    end
    for (int b = 0; b < 4; b++) begin
      sfr_wr(LEG, {3'b000, 2'(b), 3'b000});
      rd_chk("R3 banked R0", 0, 0, 0);
      rd_chk("R3 global R7", 7, 0, 0);
      ind_chk("R9 compat lo", 1, 0);
      ind_chk("R9 compat hi", 1, 1);
      ind_chk("R10 word ind", 0, 0);
    end

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op = int'($urandom_range(0, 3));
      compat_en = 1'($urandom);  // R11: mode random during all accesses
      if (op == 0)
        reg_wr(int'($urandom_range(0, 7)), 1'($urandom), 1'($urandom), 16'($urandom));
      else if (op == 1) begin
        int s = int'($urandom_range(0, 2));
        sfr_wr(s == 0 ? LEG : (s == 1 ? NAT : 8'(8'h42 + s)), 8'($urandom));
      end else @(negedge clk);
      rd_chk("R11 random read", int'($urandom_range(0, 7)), 1'($urandom), 1'($urandom));
      sfr_chk("R4 random legacy", LEG);
      sfr_chk("R8 random native", NAT);
      ind_chk("R10 random ind", 1'($urandom), int'($urandom_range(0, 7)));
      if (it % 8 == 0) alias_chk();
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule